// File: doc/BRIEF.md
# Masked GPIO Port with Level Alarms

A bidirectional general-purpose I/O port of parameterised width. Each bit has its own direction, and an output shadow register holds the values that output bits drive. A single-cycle command strobe carries a command code and a mask argument. Every write is a mask operation: a 1 in the mask selects a bit, and a 0 leaves that bit alone. A registered response word returns direction, input or shadow state.

Pins are read through a synchroniser chain. Each bit can be armed to flag a high level, a low level, or both. All armed conditions are ORed onto one level-sensitive interrupt line. That line stays asserted while any armed condition holds and drops once the condition goes away or is disarmed.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset all bits are inputs (`pin_oe` = 0), the shadow register is 0, nothing is armed, `irq` = 0 and `rsp_valid` = 0.
- R2: Command code 1 (set-out) sets every shadow bit whose mask bit is 1 and leaves every other shadow bit unchanged. An all-zero mask changes nothing.
- R3: Command code 2 (clear-out) clears every shadow bit whose mask bit is 1 and leaves every other shadow bit unchanged.
- R4: Command code 6 (get-dir) returns the direction vector, where 1 means output and 0 means input. Command code 7 (make-in) turns the masked bits into inputs, leaves the other bits unchanged, and returns the resulting input mask (the bitwise inverse of the new direction vector).
- R5: Command code 8 (make-out) turns the masked bits into outputs, leaves the other bits unchanged, and returns the resulting direction vector.
- R6: Command code 9 (get-in) returns the synchronised pin levels. A pin change becomes visible to reads and alarms after exactly two rising clock edges.
- R7: Command code 10 (get-shadow) returns the shadow register, not the pin levels, whatever the direction of each bit.
- R8: `pin_oe` equals the direction vector. `pin_out` carries a shadow bit only where the direction bit is 1, and is 0 elsewhere.
- R9: Command code 3 arms a high-level alarm and command code 4 arms a low-level alarm, for the masked bits. `irq` is the OR over all bits of (high-armed AND input) OR (low-armed AND NOT input). It is asserted in the cycle after the arming edge and stays up while the condition holds.
- R10: Command code 5 disarms both alarm kinds for the masked bits. `irq` falls when no armed condition remains.
- R11: Every accepted command raises `rsp_valid` for exactly the next cycle. `rsp_data` holds the response until the next command. Codes 1 to 5 return 0. Codes 0 and 11 to 15 change no state and return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 4 | Command code |
| cmd_arg | input | WIDTH | Mask argument |
| rsp_valid | output | 1 | Response valid, one cycle after the command |
| rsp_data | output | WIDTH | Response word |
| pin_in | input | WIDTH | Asynchronous pin levels |
| pin_out | output | WIDTH | Pin drive values |
| pin_oe | output | WIDTH | Per-pin output enable |
| irq | output | 1 | Level alarm interrupt |

## Verification
The mask writes are applied with partial masks, overlapping masks, an all-zero mask and unused codes. These patterns separate a correct read-modify-write from a plain overwrite or a write that ignores the mask. Direction changes are interleaved with shadow reads, so that a design returning pins instead of the shadow, or the old direction instead of the updated one, reports a wrong word. Alarms are armed on bits that do and do not match the current pin level, and then a pin is toggled. Sampling on both sides of the second synchroniser edge exposes a chain that is too short or too long.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int CMD_W = 4;

   typedef enum logic [CMD_W-1:0] {
      CMD_NOP        = 4'd0,
      CMD_SET_OUT    = 4'd1,
      CMD_CLR_OUT    = 4'd2,
      CMD_ARM_HIGH   = 4'd3,
      CMD_ARM_LOW    = 4'd4,
      CMD_DISARM     = 4'd5,
      CMD_GET_DIR    = 4'd6,
      CMD_MAKE_IN    = 4'd7,
      CMD_MAKE_OUT   = 4'd8,
      CMD_GET_IN     = 4'd9,
      CMD_GET_SHADOW = 4'd10
   } cmd_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_in_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d_async;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q_sync = chain[STAGES-1];

   // R6: the output is the first stage delayed by the remaining stages
   p_sync_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (STAGES != 2) || (q_sync == $past(chain[0])));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  cmd_e             cmd,
   input  logic [WIDTH-1:0] arg,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] dir_nxt,
   output logic [WIDTH-1:0] shadow_q
);
   logic [WIDTH-1:0] shadow_nxt;

   always_comb begin
      dir_nxt    = dir_q;
      shadow_nxt = shadow_q;
      if (cmd_valid) begin
         unique case (cmd)
            CMD_SET_OUT:  shadow_nxt = shadow_q | arg;
            CMD_CLR_OUT:  shadow_nxt = shadow_q & ~arg;
            CMD_MAKE_IN:  dir_nxt    = dir_q & ~arg;
            CMD_MAKE_OUT: dir_nxt    = dir_q | arg;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q    <= '0;
         shadow_q <= '0;
      end else begin
         dir_q    <= dir_nxt;
         shadow_q <= shadow_nxt;
      end
   end

   p_set_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd == CMD_SET_OUT) |=>
         ((shadow_q & $past(arg)) == $past(arg)) &&
         ((shadow_q & ~$past(arg)) == ($past(shadow_q) & ~$past(arg))));

   p_clr_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd == CMD_CLR_OUT) |=>
         ((shadow_q & $past(arg)) == '0) &&
         ((shadow_q & ~$past(arg)) == ($past(shadow_q) & ~$past(arg))));

   p_make_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd == CMD_MAKE_IN) |=>
         ((dir_q & $past(arg)) == '0) && $stable(shadow_q));

   p_make_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd == CMD_MAKE_OUT) |=>
         ((dir_q & $past(arg)) == $past(arg)) && $stable(shadow_q));

   p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> $stable(dir_q) && $stable(shadow_q));
endmodule

// File: rtl/gpio_alarm_unit.sv
module gpio_alarm_unit
   import gpio_port_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  cmd_e             cmd,
   input  logic [WIDTH-1:0] arg,
   input  logic [WIDTH-1:0] level,
   output logic             irq
);
   logic [WIDTH-1:0] hi_arm, lo_arm;
   logic [WIDTH-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_arm <= '0;
         lo_arm <= '0;
      end else if (cmd_valid) begin
         unique case (cmd)
            CMD_ARM_HIGH: hi_arm <= hi_arm | arg;
            CMD_ARM_LOW:  lo_arm <= lo_arm | arg;
            CMD_DISARM: begin
               hi_arm <= hi_arm & ~arg;
               lo_arm <= lo_arm & ~arg;
            end
            default: ;
         endcase
      end
   end

   always_comb hit = (hi_arm & level) | (lo_arm & ~level);

   generate
      if (IRQ_REG) begin : g_irq_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= |hit;
         end
      end else begin : g_irq_comb
         assign irq = |hit;
      end
   endgenerate

   p_disarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd == CMD_DISARM) |=> (((hi_arm | lo_arm) & $past(arg)) == '0));

   p_arm_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd == CMD_ARM_HIGH) |=> ((hi_arm & $past(arg)) == $past(arg)));

   p_quiet_unarmed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (IRQ_REG == 1'b0 && hi_arm == '0 && lo_arm == '0) |-> !irq);
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
   import gpio_port_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [CMD_W-1:0]   cmd_code,
   input  logic [WIDTH-1:0]   cmd_arg,
   output logic               rsp_valid,
   output logic [WIDTH-1:0]   rsp_data,
   input  logic [WIDTH-1:0]   pin_in,
   output logic [WIDTH-1:0]   pin_out,
   output logic [WIDTH-1:0]   pin_oe,
   output logic               irq
);
   generate
      if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
         $error("gpio_mask_port: WIDTH out of range 1..64");
      end
   endgenerate

   cmd_e             cmd;
   logic [WIDTH-1:0] in_sync;
   logic [WIDTH-1:0] dir_q, dir_nxt, shadow_q;
   logic [WIDTH-1:0] rsp_nxt;

   assign cmd = cmd_e'(cmd_code);

   gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(in_sync));

   gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
      .arg(cmd_arg), .dir_q(dir_q), .dir_nxt(dir_nxt), .shadow_q(shadow_q));

   gpio_alarm_unit #(.WIDTH(WIDTH), .IRQ_REG(IRQ_REG)) u_alarm (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
      .arg(cmd_arg), .level(in_sync), .irq(irq));

   always_comb begin
      unique case (cmd)
         CMD_GET_DIR:    rsp_nxt = dir_q;
         CMD_MAKE_IN:    rsp_nxt = ~dir_nxt;
         CMD_MAKE_OUT:   rsp_nxt = dir_nxt;
         CMD_GET_IN:     rsp_nxt = in_sync;
         CMD_GET_SHADOW: rsp_nxt = shadow_q;
         default:        rsp_nxt = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= cmd_valid;
         if (cmd_valid) rsp_data <= rsp_nxt;
      end
   end

   assign pin_oe  = dir_q;
   assign pin_out = shadow_q & dir_q;

   p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> rsp_valid);

   p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !rsp_valid && $stable(rsp_data));

   p_no_drive_on_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~pin_oe) == '0);
endmodule

// File: tb/gpio_mask_port_tb.sv
`timescale 1ns/1ps
module gpio_mask_port_tb_top;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_valid = 1'b0;
   logic [3:0]   cmd_code = '0;
   logic [W-1:0] cmd_arg = '0;
   logic         rsp_valid;
   logic [W-1:0] rsp_data;
   logic [W-1:0] pin_in = 8'hA5;
   logic [W-1:0] pin_out, pin_oe;
   logic         irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_mask_port #(.WIDTH(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_arg(cmd_arg), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

   // {code[3:0], arg[7:0], expected response[7:0]}, pins held at A5
   localparam int NV = 16;
   localparam logic [19:0] VEC [NV] = '{
      {4'd6,  8'hFF, 8'h00},   // R4 get-dir after reset
      {4'd1,  8'h0F, 8'h00},   // R2 set-out, returns 0 (R11)
      {4'd10, 8'h00, 8'h0F},   // R7 shadow read
      {4'd2,  8'h05, 8'h00},   // R3 clear-out
      {4'd10, 8'h00, 8'h0A},   // R3 other bits kept
      {4'd8,  8'hF0, 8'hF0},   // R5 make-out
      {4'd8,  8'h03, 8'hF3},   // R5 accumulates
      {4'd7,  8'h30, 8'h3C},   // R4 make-in returns input mask
      {4'd6,  8'h00, 8'hC3},   // R4 direction vector
      {4'd9,  8'h00, 8'hA5},   // R6 pin levels
      {4'd10, 8'h00, 8'h0A},   // R7 shadow, not pins
      {4'd1,  8'h00, 8'h00},   // R2 zero mask
      {4'd10, 8'h00, 8'h0A},   // R2 nothing changed
      {4'd12, 8'hFF, 8'h00},   // R11 unused code
      {4'd6,  8'h00, 8'hC3},   // R11 direction untouched
      {4'd10, 8'h00, 8'h0A}    // R11 shadow untouched
   };

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [3:0] code, input logic [W-1:0] arg);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = code; cmd_arg = arg;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_code = '0; cmd_arg = '0;
      check("R11 rsp_valid", {7'd0, rsp_valid}, 8'd1);
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 pin_oe", pin_oe, 8'h00);
      check("R1 pin_out", pin_out, 8'h00);
      check("R1 irq", {7'd0, irq}, 8'h00);
      check("R1 rsp_valid", {7'd0, rsp_valid}, 8'h00);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         issue(VEC[i][19:16], VEC[i][15:8]);
         check($sformatf("vector %0d code %0d", i, VEC[i][19:16]), rsp_data, VEC[i][7:0]);
      end

      // R11 response held without a command
      @(negedge clk);
      check("R11 rsp_valid low", {7'd0, rsp_valid}, 8'h00);
      check("R11 rsp_data held", rsp_data, 8'h0A);

      // R8 pin drive: shadow 0A, dir C3
      check("R8 pin_oe", pin_oe, 8'hC3);
      check("R8 pin_out", pin_out, 8'h02);

      // R9 alarms, pins A5
      issue(4'd3, 8'h02);
      check("R9 high arm on low pin", {7'd0, irq}, 8'h00);
      issue(4'd4, 8'h40);
      check("R9 low arm on low pin", {7'd0, irq}, 8'h01);
      // R10 disarm
      issue(4'd5, 8'h40);
      check("R10 irq after disarm", {7'd0, irq}, 8'h00);
      issue(4'd5, 8'h02);
      issue(4'd3, 8'h01);
      check("R9 high arm on high pin", {7'd0, irq}, 8'h01);

      // R6 sync latency: pin bit0 drops
      pin_in = 8'hA4;
      @(negedge clk);
      check("R6 one edge later irq", {7'd0, irq}, 8'h01);
      @(negedge clk);
      check("R6 two edges later irq", {7'd0, irq}, 8'h00);
      issue(4'd9, 8'h00);
      check("R6 get-in", rsp_data, 8'hA4);
      issue(4'd5, 8'hFF);
      issue(4'd4, 8'h01);
      check("R9 low arm after change", {7'd0, irq}, 8'h01);

      // R1 reset again
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 irq cleared", {7'd0, irq}, 8'h00);
      check("R1 pin_oe cleared", pin_oe, 8'h00);
      check("R1 pin_out cleared", pin_out, 8'h00);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      issue(4'd10, 8'h00);
      check("R1 shadow cleared", rsp_data, 8'h00);
      issue(4'd6, 8'h00);
      check("R1 dir cleared", rsp_data, 8'h00);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule